// File: doc/BRIEF.md
# I2C Master Byte Engine

This block is the bus-side half of a two-wire serial master. A host steps it one bus action at a time through a small command port. The actions are: claim the bus, re-claim it without releasing it, release it, send a byte, and receive a byte. The block drives the clock and data lines only through drive-low enables, so an external pull-up or an open-drain pad completes each line. It reads the data line back through a synchronizer.

Each byte action runs nine clock pulses: eight data bits, most significant first, and then the acknowledge slot. When the ninth pulse ends, the engine keeps the clock line pulled low and raises a completion flag. It takes no new command until the host clears that flag, so software sets the pace of the transfer one byte at a time. An address phase is an ordinary send-byte whose least significant bit is the read/write direction. The host chooses what follows a refused byte: a release, or a re-claim.

Bit timing comes from a programmable quarter-period count. Every bit slot has four equal quarters with the clock low, high, high, low. Data changes only at the start of the first low quarter. The returning data bit is sampled at the middle of the high half.

Top module: `i2c_byte_engine`

## Requirements
- R1: During a send-byte or receive-byte action, `sdaDrvLow` never changes while `sclDrvLow` is 0, both in the current cycle and in the one before.
- R2: A send-byte places the eight bits of `txByte` on the data line, most significant first, one per clock pulse, each valid at the rising clock edge.
- R3: Every byte action produces exactly nine rising clock edges. A re-claim produces one, a release produces one, and a claim from the idle bus produces none.
- R4: In the ninth pulse of a send-byte, the master releases the data line. `rxAck` becomes 1 if the line was low at mid-high (acknowledged) and 0 if it was high (refused).
- R5: During a receive-byte, the master releases the data line for bits 0 to 7 and assembles them into `rxByte`, most significant first. In the ninth pulse it pulls the data line low when `ackToSend` was 1 at the command, and leaves it released when `ackToSend` was 0.
- R6: At the end of each byte action, `irqFlag` goes to 1 in the same cycle that `busy` drops. While `irqFlag` is 1, `sclDrvLow` stays 1. `irqClr` returns the flag to 0.
- R7: A command is accepted only when `cmdValid` is 1, `busy` is 0 and `irqFlag` is 0. `cmdOp` encodes claim=1, re-claim=2, release=3, send=4, receive=5. Any other code, and any command offered while busy or flagged, has no effect on the lines or on `busy`.
- R8: A claim from the idle bus pulls the data line low while the clock line is high, and then pulls the clock line low.
- R9: A re-claim first releases the data line while the clock is low, then releases the clock, then pulls the data line low while the clock is high, and finally pulls the clock low.
- R10: A release raises the data line while the clock is high, and afterwards both `sclDrvLow` and `sdaDrvLow` are 0.
- R11: One quarter lasts `divQuarter`+1 clock cycles, so each data-bit clock pulse stays high for 2×(`divQuarter`+1) cycles. `divQuarter` must be at least 3.
- R12: After reset, both drive enables, `busy` and `irqFlag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 3 | Command code (see R7) |
| txByte | input | 8 | Byte to send with a send-byte command |
| ackToSend | input | 1 | 1 = acknowledge the received byte, 0 = refuse it |
| irqClr | input | 1 | Clears the completion flag |
| divQuarter | input | DIV_W | Quarter-period length minus one |
| sdaIn | input | 1 | Data line level read back from the pad |
| sclDrvLow | output | 1 | 1 pulls the clock line low |
| sdaDrvLow | output | 1 | 1 pulls the data line low |
| busy | output | 1 | An action is in progress |
| irqFlag | output | 1 | Byte-complete flag |
| rxByte | output | 8 | Last received byte |
| rxAck | output | 1 | 1 = last sent byte was acknowledged |

## Verification
The bound checker watches several properties on every cycle. It checks that data stays stable across clock-high time inside byte actions. It checks that the clock stays held low while the completion flag is up, and that the flag rises only as `busy` falls. It also checks that `busy` starts only from a command strobe and that no command starts while the flag is set. Other behaviour can only be shown by the bench's scenarios, because each needs a modelled slave and a monitor on the line waveforms. That covers the bit order of sent and received bytes, the acknowledge handling in both directions, the edge orderings of claim, re-claim and release, the pulse counts, and the measured high time.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_START   = 3'd1,
    OP_RESTART = 3'd2,
    OP_STOP    = 3'd3,
    OP_WRITE   = 3'd4,
    OP_READ    = 3'd5
  } busOp_e;

  // strobes from control to datapath, one cycle wide
  typedef struct packed {
    logic load;         // take txByte into the shifter
    logic capture;      // sample the synchronized data line (mid-high)
    logic shift;        // advance to the next bit (end of slot)
    logic finishRead;   // publish the received byte
    logic finishWrite;  // publish the acknowledge seen in slot 9
  } dpStrobe_t;
endpackage

// File: rtl/i2c_eng_dp.sv
module i2c_eng_dp
  import i2c_eng_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpStrobe_t         stb,
  input  logic [BYTE_W-1:0] txByte,
  input  logic              sdaIn,
  output logic              txMsb,
  output logic [BYTE_W-1:0] rxByte,
  output logic              rxAck
);
  logic sdaSync;

  generate
    if (SYNC_STAGES <= 1) begin : g_sync1
      logic syncReg;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) syncReg <= 1'b1;
        else        syncReg <= sdaIn;
      end
      assign sdaSync = syncReg;
    end else begin : g_syncN
      logic [SYNC_STAGES-1:0] syncChain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) syncChain <= '1;
        else        syncChain <= {syncChain[SYNC_STAGES-2:0], sdaIn};
      end
      assign sdaSync = syncChain[SYNC_STAGES-1];
    end
  endgenerate

  logic [BYTE_W-1:0] shiftReg;
  logic              capBit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg <= '1;
      capBit   <= 1'b1;
      rxByte   <= '0;
      rxAck    <= 1'b0;
    end else begin
      if (stb.load)         shiftReg <= txByte;
      else if (stb.shift)   shiftReg <= {shiftReg[BYTE_W-2:0], capBit};
      if (stb.capture)      capBit   <= sdaSync;
      if (stb.finishRead)   rxByte   <= {shiftReg[BYTE_W-2:0], capBit};
      if (stb.finishWrite)  rxAck    <= ~capBit;
    end
  end

  assign txMsb = shiftReg[BYTE_W-1];
endmodule

// File: rtl/i2c_eng_ctrl.sv
module i2c_eng_ctrl
  import i2c_eng_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmdValid,
  input  logic [2:0]       cmdOp,
  input  logic             ackToSend,
  input  logic             irqClr,
  input  logic [DIV_W-1:0] divQuarter,
  input  logic             txMsb,
  output dpStrobe_t        stb,
  output logic             sclDrvLow,
  output logic             sdaDrvLow,
  output logic             busy,
  output logic             irqFlag
);
  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(BYTE_W);

  typedef enum logic [1:0] {S_IDLE, S_PARK, S_RUN} state_e;

  state_e           state;
  busOp_e           opReg;
  logic             ackReg;
  logic [DIV_W-1:0] qCnt;
  logic [1:0]       phase;
  logic [CNT_W-1:0] slotCnt;

  logic opKnown, accept, qEnd, byteOp, slotEnd, actionEnd, dataSlot;

  assign opKnown   = (cmdOp >= 3'd1) && (cmdOp <= 3'd5);
  assign accept    = cmdValid && (state != S_RUN) && !irqFlag && opKnown;
  assign qEnd      = (qCnt == divQuarter);
  assign byteOp    = (opReg == OP_WRITE) || (opReg == OP_READ);
  assign slotEnd   = (state == S_RUN) && qEnd && (phase == 2'd3);
  assign actionEnd = slotEnd && (!byteOp || (slotCnt == LAST_SLOT));
  assign dataSlot  = (slotCnt < LAST_SLOT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      opReg   <= OP_NONE;
      ackReg  <= 1'b0;
      qCnt    <= '0;
      phase   <= '0;
      slotCnt <= '0;
    end else if (accept) begin
      state   <= S_RUN;
      opReg   <= busOp_e'(cmdOp);
      ackReg  <= ackToSend;
      qCnt    <= '0;
      phase   <= '0;
      slotCnt <= '0;
    end else if (state == S_RUN) begin
      if (qEnd) begin
        qCnt  <= '0;
        phase <= phase + 2'd1;
        if (phase == 2'd3) slotCnt <= slotCnt + CNT_W'(1);
        if (actionEnd) state <= (opReg == OP_STOP) ? S_IDLE : S_PARK;
      end else begin
        qCnt <= qCnt + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 irqFlag <= 1'b0;
    else if (actionEnd && byteOp) irqFlag <= 1'b1;
    else if (irqClr)            irqFlag <= 1'b0;
  end

  // strobes toward the datapath
  always_comb begin
    stb             = '0;
    stb.load        = accept;
    stb.capture     = (state == S_RUN) && byteOp && qEnd && (phase == 2'd1);
    stb.shift       = slotEnd && byteOp && dataSlot;
    stb.finishRead  = slotEnd && (opReg == OP_READ) && (slotCnt == LAST_SLOT - CNT_W'(1));
    stb.finishWrite = slotEnd && (opReg == OP_WRITE) && (slotCnt == LAST_SLOT);
  end

  // line levels per quarter: slot is low, high, high, low for the clock
  logic dataLow, nextScl, nextSda;
  assign dataLow = (opReg == OP_WRITE) ? (dataSlot ? ~txMsb : 1'b0)
                                       : (dataSlot ? 1'b0 : ackReg);

  always_comb begin
    nextScl = 1'b0;
    nextSda = 1'b0;
    unique case (state)
      S_IDLE: begin
        nextScl = 1'b0;
        nextSda = 1'b0;
      end
      S_PARK: begin
        nextScl = 1'b1;
        nextSda = sdaDrvLow;
      end
      default: begin
        case (opReg)
          OP_START: begin
            nextScl = (phase == 2'd3);
            nextSda = (phase >= 2'd2);
          end
          OP_RESTART: begin
            nextScl = (phase == 2'd0) || (phase == 2'd3);
            nextSda = (phase >= 2'd2);
          end
          OP_STOP: begin
            nextScl = (phase == 2'd0);
            nextSda = (phase <= 2'd1);
          end
          default: begin
            nextScl = (phase == 2'd0) || (phase == 2'd3);
            nextSda = dataLow;
          end
        endcase
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclDrvLow <= 1'b0;
      sdaDrvLow <= 1'b0;
    end else begin
      sclDrvLow <= nextScl;
      sdaDrvLow <= nextSda;
    end
  end

  assign busy = (state == S_RUN);
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_eng_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmdValid,
  input  logic [2:0]       cmdOp,
  input  logic [7:0]       txByte,
  input  logic             ackToSend,
  input  logic             irqClr,
  input  logic [DIV_W-1:0] divQuarter,
  input  logic             sdaIn,
  output logic             sclDrvLow,
  output logic             sdaDrvLow,
  output logic             busy,
  output logic             irqFlag,
  output logic [7:0]       rxByte,
  output logic             rxAck
);
  dpStrobe_t stb;
  logic      txMsb;

  i2c_eng_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .ackToSend(ackToSend), .irqClr(irqClr), .divQuarter(divQuarter),
    .txMsb(txMsb), .stb(stb), .sclDrvLow(sclDrvLow), .sdaDrvLow(sdaDrvLow),
    .busy(busy), .irqFlag(irqFlag)
  );

  i2c_eng_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .txByte(txByte), .sdaIn(sdaIn),
    .txMsb(txMsb), .rxByte(rxByte), .rxAck(rxAck)
  );
endmodule

// File: rtl/i2c_byte_engine_chk.sv
module i2c_byte_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmdValid,
  input logic [2:0] cmdOp,
  input logic       busy,
  input logic       irqFlag,
  input logic       sclDrvLow,
  input logic       sdaDrvLow
);
  // tracks, from the ports only, that a byte action is under way
  logic inByte;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inByte <= 1'b0;
    else if (cmdValid && !busy && !irqFlag && (cmdOp == 3'd4 || cmdOp == 3'd5)) inByte <= 1'b1;
    else if (irqFlag) inByte <= 1'b0;
  end

  assert_sda_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (inByte && !sclDrvLow && $past(!sclDrvLow)) |-> $stable(sdaDrvLow));

  assert_irq_holds_scl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irqFlag |-> sclDrvLow);

  assert_irq_at_byte_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irqFlag) |-> $fell(busy));

  assert_start_needs_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmdValid));

  assert_flag_blocks_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && irqFlag) |=> !busy);
endmodule

bind i2c_byte_engine i2c_byte_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdOp(cmdOp),
  .busy(busy), .irqFlag(irqFlag), .sclDrvLow(sclDrvLow), .sdaDrvLow(sdaDrvLow)
);

// File: tb/i2c_byte_engine_tb.sv
module i2c_byte_engine_tb;
  localparam int PERIOD = 10;
  localparam int DIV_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmdValid = 1'b0;
  logic [2:0] cmdOp = 3'd0;
  logic [7:0] txByte = 8'h00;
  logic ackToSend = 1'b0;
  logic irqClr = 1'b0;
  logic [DIV_W-1:0] divQuarter = 8'd3;
  logic sclDrvLow, sdaDrvLow, busy, irqFlag, rxAck;
  logic [7:0] rxByte;
  logic sclLine, sdaLine, slvLow;

  int checks = 0;
  int errors = 0;

  // slave model state
  int slvMode = 0;          // 0 passive, 1 acknowledging receiver, 2 transmitter
  logic slvAck = 1'b0;
  logic [7:0] slvData = 8'h00;
  int bitIdx = 0;

  // line monitors
  int riseCnt = 0;
  logic [7:0] obsByte = 8'h00;
  logic obsAck = 1'b0;
  int startSeen = 0;
  int stopSeen = 0;
  int glitches = 0;
  int inByteAct = 0;
  longint tRise = 0;
  longint highCycles = 0;

  always #(PERIOD/2) clk = ~clk;

  assign sclLine = ~sclDrvLow;
  assign slvLow = (slvMode == 1 && bitIdx == 8 && slvAck) ||
                  (slvMode == 2 && bitIdx < 8 && !slvData[(bitIdx < 8) ? (7 - bitIdx) : 0]);
  assign sdaLine = ~(sdaDrvLow | slvLow);

  i2c_byte_engine #(.DIV_W(DIV_W), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdOp(cmdOp), .txByte(txByte),
    .ackToSend(ackToSend), .irqClr(irqClr), .divQuarter(divQuarter), .sdaIn(sdaLine),
    .sclDrvLow(sclDrvLow), .sdaDrvLow(sdaDrvLow), .busy(busy), .irqFlag(irqFlag),
    .rxByte(rxByte), .rxAck(rxAck)
  );

  always @(posedge sclLine) begin
    riseCnt = riseCnt + 1;
    tRise = $time;
    if (riseCnt <= 8) obsByte = {obsByte[6:0], sdaLine};
    if (riseCnt == 9) obsAck = sdaLine;
  end
  always @(negedge sclLine) begin
    bitIdx = bitIdx + 1;
    highCycles = ($time - tRise) / PERIOD;
  end
  always @(negedge sdaLine) begin
    if (sclLine) begin
      startSeen = startSeen + 1;
      if (inByteAct != 0) glitches = glitches + 1;
    end
  end
  always @(posedge sdaLine) begin
    if (sclLine) begin
      stopSeen = stopSeen + 1;
      if (inByteAct != 0) glitches = glitches + 1;
    end
  end

  task automatic checkEq(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic expAckLine(input logic ack);
    return ack ? 1'b0 : 1'b1;
  endfunction

  task automatic clearMon();
    riseCnt = 0; bitIdx = 0; startSeen = 0; stopSeen = 0; glitches = 0;
  endtask

  task automatic pulseCmd(input logic [2:0] op, input logic [7:0] b, input logic ack);
    @(negedge clk);
    cmdOp = op; txByte = b; ackToSend = ack; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic runCmd(input logic [2:0] op, input logic [7:0] b, input logic ack);
    clearMon();
    inByteAct = (op == 3'd4 || op == 3'd5) ? 1 : 0;
    pulseCmd(op, b, ack);
    waitIdle();
    inByteAct = 0;
  endtask

  task automatic clearIrq();
    @(negedge clk); irqClr = 1'b1;
    @(negedge clk); irqClr = 1'b0;
  endtask

  task automatic doWrite(input logic [7:0] b, input logic sAck);
    slvMode = 1; slvAck = sAck;
    runCmd(3'd4, b, 1'b0);
    slvMode = 0;
    checkEq("R2 sent byte", obsByte, b);
    checkEq("R3 pulses per byte", riseCnt, 9);
    checkEq("R4 master releases ack slot", obsAck, expAckLine(sAck));
    checkEq("R4 rxAck", rxAck, sAck);
    checkEq("R1 data stable while clock high", glitches, 0);
    checkEq("R6 flag set", irqFlag, 1);
    checkEq("R6 clock held", sclDrvLow, 1);
    checkEq("R11 high time", highCycles, 2 * (divQuarter + 1));
  endtask

  task automatic doRead(input logic [7:0] d, input logic ack);
    slvMode = 2; slvData = d;
    runCmd(3'd5, 8'h00, ack);
    slvMode = 0;
    checkEq("R5 rxByte", rxByte, d);
    checkEq("R5 ack driven by master", obsAck, expAckLine(ack));
    checkEq("R3 pulses per byte", riseCnt, 9);
    checkEq("R1 data stable while clock high", glitches, 0);
    checkEq("R6 flag set", irqFlag, 1);
  endtask

  task automatic runTests();
    repeat (5) @(negedge clk);
    // R12 reset state
    checkEq("R12 scl enable", sclDrvLow, 0);
    checkEq("R12 sda enable", sdaDrvLow, 0);
    checkEq("R12 busy", busy, 0);
    checkEq("R12 flag", irqFlag, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8 claim from idle
    divQuarter = 8'd3;
    runCmd(3'd1, 8'h00, 1'b0);
    checkEq("R8 start edge", startSeen, 1);
    checkEq("R3 start pulses", riseCnt, 0);
    checkEq("R8 clock pulled low after start", sclDrvLow, 1);
    checkEq("R8 no flag after start", irqFlag, 0);

    // address byte with read/write bit, acknowledged
    doWrite(8'hA4, 1'b1);

    // R7 command ignored while flagged
    clearMon();
    pulseCmd(3'd4, 8'h5A, 1'b0);
    repeat (40) @(negedge clk);
    checkEq("R7 ignored while flagged busy", busy, 0);
    checkEq("R7 ignored while flagged pulses", riseCnt, 0);
    clearIrq();
    checkEq("R6 flag cleared", irqFlag, 0);

    // random mix
    for (int i = 0; i < 20; i++) begin
      logic [7:0] v;
      logic a;
      v = 8'($urandom);
      a = 1'($urandom);
      divQuarter = DIV_W'(3 + ($urandom % 4));
      if (($urandom % 2) == 0) doWrite(v, a);
      else doRead(v, a);
      clearIrq();
    end

    // corner bytes
    divQuarter = 8'd5;
    doWrite(8'h00, 1'b1); clearIrq();
    doWrite(8'hFF, 1'b0); clearIrq();
    doRead(8'h80, 1'b0); clearIrq();
    doRead(8'h01, 1'b1); clearIrq();

    // R7 command while busy ignored
    clearMon();
    slvMode = 1; slvAck = 1'b1;
    inByteAct = 1;
    pulseCmd(3'd4, 8'hC3, 1'b0);
    repeat (6) @(negedge clk);
    pulseCmd(3'd5, 8'h00, 1'b1);
    waitIdle();
    inByteAct = 0; slvMode = 0;
    checkEq("R7 busy command ignored pulses", riseCnt, 9);
    checkEq("R7 busy command ignored byte", obsByte, 8'hC3);
    clearIrq();

    // R7 unknown codes
    clearMon();
    pulseCmd(3'd0, 8'h00, 1'b0);
    pulseCmd(3'd7, 8'h00, 1'b0);
    repeat (30) @(negedge clk);
    checkEq("R7 unknown code busy", busy, 0);
    checkEq("R7 unknown code pulses", riseCnt, 0);

    // refused byte then re-claim
    doWrite(8'h3C, 1'b0);
    clearIrq();
    runCmd(3'd2, 8'h00, 1'b0);
    checkEq("R9 restart pulses", riseCnt, 1);
    checkEq("R9 data released at clock rise", obsByte[0], 1);
    checkEq("R9 start edge", startSeen, 1);
    checkEq("R9 no stop edge", stopSeen, 0);
    checkEq("R9 clock low after", sclDrvLow, 1);

    doRead(8'h96, 1'b0); clearIrq();

    // R10 release
    runCmd(3'd3, 8'h00, 1'b0);
    checkEq("R10 stop edge", stopSeen, 1);
    checkEq("R10 data low at clock rise", obsByte[0], 0);
    checkEq("R10 scl released", sclDrvLow, 0);
    checkEq("R10 sda released", sdaDrvLow, 0);
    checkEq("R10 busy", busy, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    fork
      runTests();
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule